// File: doc/BRIEF.md
# Section-Based Variable-Length Codeword Encoder

This block turns a 4-bit symbol index into a prefix-free codeword of 2 to 6 bits. It does not hold a full codeword table. It keeps two small tables instead. The first is a rank table. It gives each symbol its position in the ascending order of all codewords, each codeword padded with zeros on the right to 8 bits. The second is a section table with one entry for each run of codewords that have the same length and consecutive values. Each entry holds the padded codeword, the length and the rank of the lowest-ranked member of its run. The section table stores only the upper 6 bits of each padded word. The lowest 2 bits of every padded codeword are zero, and fixed wiring supplies them.

Comparator logic finds the section from the symbol's rank. Two subtractors then form the rank distance to the section's first member and the shift amount (8 minus the length). A shifter and an adder rebuild the codeword. The result leaves the block left-aligned in an 8-bit field, together with its length.

Symbols enter and codewords leave through valid/ready handshakes. The three pipeline stages advance together whenever the output stage is empty or is being drained. The input is therefore ready exactly when the output is not stalled. A stalled output holds its word unchanged. Bubbles are not squeezed out of the pipeline.

Top module: `vlc_sec_enc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A symbol s is ranked (7*s + 3) mod 16. Symbol 12 has rank 7 and symbol 3 has rank 8.
- R3: The sections are defined by rank. Each section is listed as its ranks, its length and the code of its first member:
  - ranks 0, length 2, code 00
  - ranks 1–2, length 3, code 010
  - ranks 3–5, length 4, code 1000
  - ranks 6–7, length 5, code 10110
  - ranks 8–9, length 5, code 11001
  - ranks 10–15, length 6, code 110110

  The code for any rank r is the first member's code plus (r − first rank of the section).
- R4: out_code carries the codeword in its upper out_len bits, with bit 7 as the first bit sent. All bits below the codeword are 0, and out_len is between 2 and 6.
- R5: With out_ready held at 1, a symbol accepted on one rising edge appears on the outputs after the second rising edge that follows it. A new symbol can be accepted on every cycle.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid, out_code and out_len do not change.
- R7: Every accepted symbol produces exactly one output, in acceptance order. No output appears without an accepted symbol.
- R8: The gap between the two length-5 sections is honoured. The code 11000 is never emitted, rank 7 gives 10111 and rank 8 gives 11001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol is offered |
| in_ready | output | 1 | The block takes the offered symbol on this edge |
| in_sym | input | 4 | Symbol index |
| out_valid | output | 1 | A codeword is presented |
| out_ready | input | 1 | The sink takes the codeword on this edge |
| out_code | output | 8 | Left-aligned codeword, zero below its length |
| out_len | output | 4 | Codeword length in bits |

## Verification
The bench pays most attention to section edges: rank 7 against rank 8 across the gap at 11000, and the first and last members of each section. A design that picks the wrong section there emits a codeword that belongs to a neighbour, or has the wrong length. The bench also holds out_ready low at random moments. A design that lets the pipeline advance during a stall would drop a word, duplicate one, or change out_code while it is held. An isolated symbol measures the fill latency, which catches a missing or extra register stage. A full sweep of all sixteen symbols exposes an error in the rank permutation or in the restored zero bits.

// File: rtl/vlc_sec_pkg.sv
package vlc_sec_pkg;
  localparam int NSYM  = 16;
  localparam int SYMW  = $clog2(NSYM);
  localparam int RANKW = $clog2(NSYM);
  localparam int W     = 8;
  localparam int LENW  = 4;
  localparam int PADZ  = 2;
  localparam int SW    = W - PADZ;
  localparam int NSEC  = 6;
  localparam int MULT  = 7;
  localparam int OFFS  = 3;

  typedef struct packed {
    logic [SW-1:0]    cw;
    logic [LENW-1:0]  len;
    logic [RANKW-1:0] rank;
  } sec_ent_t;

  function automatic logic [RANKW-1:0] sym_rank(input int s);
    return RANKW'((MULT * s + OFFS) % NSYM);
  endfunction

  function automatic sec_ent_t sec_entry(input int idx);
    sec_ent_t e;
    case (idx)
      0:       e = '{cw: 6'h00, len: 4'd2, rank: 4'd0};
      1:       e = '{cw: 6'h10, len: 4'd3, rank: 4'd1};
      2:       e = '{cw: 6'h20, len: 4'd4, rank: 4'd3};
      3:       e = '{cw: 6'h2C, len: 4'd5, rank: 4'd6};
      4:       e = '{cw: 6'h32, len: 4'd5, rank: 4'd8};
      default: e = '{cw: 6'h36, len: 4'd6, rank: 4'd10};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/vlc_rank_rom.sv
module vlc_rank_rom
  import vlc_sec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_vld,
  input  logic [SYMW-1:0]  sym,
  output logic             s1_vld,
  output logic [RANKW-1:0] s1_rank
);
  logic [RANKW-1:0] tbl [NSYM];

  for (genvar g = 0; g < NSYM; g++) begin : g_tbl
    assign tbl[g] = sym_rank(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_rank <= '0;
    end else if (en) begin
      s1_vld  <= in_vld;
      s1_rank <= tbl[sym];
    end
  end

  AST_RANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(s1_rank) && $stable(s1_vld)); // R6
endmodule

// File: rtl/vlc_sec_map.sv
module vlc_sec_map
  import vlc_sec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_vld,
  input  logic [RANKW-1:0] rank,
  output logic             s2_vld,
  output logic [RANKW-1:0] s2_diff,
  output logic [LENW-1:0]  s2_shamt,
  output logic [SW-1:0]    s2_cw,
  output logic [LENW-1:0]  s2_len
);
  logic [NSEC-1:0] hit;
  sec_ent_t        sel;

  for (genvar i = 0; i < NSEC; i++) begin : g_hit
    localparam sec_ent_t E = sec_entry(i);
    if (i == 0) begin : g_first
      localparam sec_ent_t N = sec_entry(i + 1);
      assign hit[i] = (rank < N.rank);
    end else if (i == NSEC - 1) begin : g_last
      assign hit[i] = (rank >= E.rank);
    end else begin : g_mid
      localparam sec_ent_t N = sec_entry(i + 1);
      assign hit[i] = (rank >= E.rank) && (rank < N.rank);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NSEC; i++) begin
      if (hit[i]) sel = sel | sec_entry(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_diff  <= '0;
      s2_shamt <= '0;
      s2_cw    <= '0;
      s2_len   <= '0;
    end else if (en) begin
      s2_vld   <= in_vld;
      s2_diff  <= rank - sel.rank;
      s2_shamt <= LENW'(W) - sel.len;
      s2_cw    <= sel.cw;
      s2_len   <= sel.len;
    end
  end

  AST_ONE_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> $onehot(hit)); // R3
endmodule

// File: rtl/vlc_cgen.sv
module vlc_cgen
  import vlc_sec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_vld,
  input  logic [RANKW-1:0] diff,
  input  logic [LENW-1:0]  shamt,
  input  logic [SW-1:0]    cw,
  input  logic [LENW-1:0]  len,
  output logic             o_vld,
  output logic [W-1:0]     o_code,
  output logic [LENW-1:0]  o_len
);
  logic [W-1:0] base;
  logic [W-1:0] offs;
  logic [W-1:0] sum;

  if (PADZ > 0) begin : g_pad
    assign base = {cw, {PADZ{1'b0}}};
  end else begin : g_nopad
    assign base = W'(cw);
  end

  assign offs = W'(diff) << shamt;
  assign sum  = base + offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_code <= '0;
      o_len  <= '0;
    end else if (en) begin
      o_vld  <= in_vld;
      o_code <= sum;
      o_len  <= len;
    end
  end

  AST_DIFF_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ((W'(diff) >> len) == '0)); // R3
endmodule

// File: rtl/vlc_sec_enc.sv
module vlc_sec_enc
  import vlc_sec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SYMW-1:0] in_sym,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_code,
  output logic [LENW-1:0] out_len
);
  logic             adv;
  logic             s1_vld, s2_vld;
  logic [RANKW-1:0] s1_rank, s2_diff;
  logic [LENW-1:0]  s2_shamt, s2_len;
  logic [SW-1:0]    s2_cw;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  vlc_rank_rom u_rank (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(in_valid), .sym(in_sym),
    .s1_vld(s1_vld), .s1_rank(s1_rank)
  );

  vlc_sec_map u_map (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(s1_vld), .rank(s1_rank),
    .s2_vld(s2_vld), .s2_diff(s2_diff), .s2_shamt(s2_shamt),
    .s2_cw(s2_cw), .s2_len(s2_len)
  );

  vlc_cgen u_cgen (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_vld(s2_vld), .diff(s2_diff),
    .shamt(s2_shamt), .cw(s2_cw), .len(s2_len),
    .o_vld(out_valid), .o_code(out_code), .o_len(out_len)
  );

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_len)); // R6
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len >= 4'd2 && out_len <= 4'd6); // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (W'(out_code << out_len) == '0)); // R4
  AST_NO_GAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_len == 4'd5 && out_code[W-1 -: 5] == 5'b11000)); // R8
endmodule

// File: tb/vlc_sec_enc_test.sv
module vlc_sec_enc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_sym = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_code;
  logic [3:0] out_len;

  int tests = 0, fails = 0, cyc = 0;
  int q_code[$], q_len[$], q_cyc[$];
  int n_acc = 0, n_pop = 0;
  bit lat_mode = 0, rand_ready = 0, done = 0;
  bit prev_stall = 0;
  logic [7:0] prev_code;
  logic [3:0] prev_len;
  logic [7:0] ref_code [16];
  logic [3:0] ref_len  [16];

  always #2 clk = ~clk;

  vlc_sec_enc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_len(out_len)
  );

  initial begin
    ref_code[0]  = 8'h00; ref_len[0]  = 4'd2;
    ref_code[1]  = 8'h40; ref_len[1]  = 4'd3;
    ref_code[2]  = 8'h60; ref_len[2]  = 4'd3;
    ref_code[3]  = 8'h80; ref_len[3]  = 4'd4;
    ref_code[4]  = 8'h90; ref_len[4]  = 4'd4;
    ref_code[5]  = 8'hA0; ref_len[5]  = 4'd4;
    ref_code[6]  = 8'hB0; ref_len[6]  = 4'd5;
    ref_code[7]  = 8'hB8; ref_len[7]  = 4'd5;
    ref_code[8]  = 8'hC8; ref_len[8]  = 4'd5;
    ref_code[9]  = 8'hD0; ref_len[9]  = 4'd5;
    ref_code[10] = 8'hD8; ref_len[10] = 4'd6;
    ref_code[11] = 8'hDC; ref_len[11] = 4'd6;
    ref_code[12] = 8'hE0; ref_len[12] = 4'd6;
    ref_code[13] = 8'hE4; ref_len[13] = 4'd6;
    ref_code[14] = 8'hE8; ref_len[14] = 4'd6;
    ref_code[15] = 8'hEC; ref_len[15] = 4'd6;
  end

  function automatic int rank_of(input int s);
    return (7 * s + 3) % 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model, evaluated every cycle away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall) begin
        chk(out_valid && out_code == prev_code && out_len == prev_len,
            "R6 held output", {out_valid, out_code, out_len}, {1'b1, prev_code, prev_len});
      end
      if (!out_valid || out_ready) begin
        if (!in_ready) chk(0, "R6 in_ready during no stall", 0, 1);
      end else if (in_ready) chk(0, "R6 in_ready during stall", 1, 0);
      if (out_valid && out_ready) begin
        if (q_code.size() == 0) chk(0, "R7 spurious output", out_code, 0);
        else begin
          int ec, el, ac;
          ec = q_code.pop_front(); el = q_len.pop_front(); ac = q_cyc.pop_front();
          n_pop++;
          chk(out_code == ec[7:0] && out_len == el[3:0], "R2/R3/R4 codeword",
              {out_code, out_len}, {ec[7:0], el[3:0]});
          if (lat_mode) chk(cyc - ac == 3, "R5 latency", cyc - ac, 3);
        end
      end
      if (in_valid && in_ready) begin
        int r;
        r = rank_of(int'(in_sym));
        q_code.push_back(int'(ref_code[r]));
        q_len.push_back(int'(ref_len[r]));
        q_cyc.push_back(cyc);
        n_acc++;
      end
      prev_stall = out_valid && !out_ready;
      prev_code  = out_code;
      prev_len   = out_len;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_ready) out_ready <= ($urandom % 3) != 0;
    else out_ready <= 1'b1;
  end

  task automatic send(input int s);
    bit ok;
    in_valid = 1'b1;
    in_sym   = 4'(s);
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    idle(3);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(2);
    // R5: isolated symbol, ready always high
    lat_mode = 1;
    send(5);
    idle(6);
    // R3: all sixteen symbols back to back
    for (int s = 0; s < 16; s++) begin
      in_valid = 1'b1; in_sym = 4'(s);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    idle(6);
    // R8: the two ranks around the section gap
    send(12);
    send(3);
    idle(6);
    lat_mode = 0;
    // R6/R7: random traffic under back-pressure
    rand_ready = 1;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 4 != 0) send($urandom % 16);
      else idle(1);
    end
    rand_ready = 0;
    idle(10);
    chk(q_code.size() == 0 && n_acc == n_pop, "R7 all accepted drained", n_pop, n_acc);
    finish_run();
  end
endmodule